// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block sits between a serial configuration slave and a clock synthesizer and decides which settings steer the synthesizer. It samples a 5-bit strap bus while reset is held and keeps that value for the rest of the run. It holds a small bank of configuration fields written through a simple byte-wide write port. From these fields, the latched straps and a recovery-mode level driven by a watchdog, it produces the active ratio-table index, the active multiplier N and divider M, a mode flag, and a one-cycle change pulse.

Two control bits layer the choice. One selects fixed-table mode or programmed N/M mode. The other selects the source of the ratio index: the latched straps or a 5-bit select field. Recovery mode overrides both. In recovery it either falls back to the straps in table mode, or applies a separate recovery N/M pair. Each N/M pair is checked against the rule (N+3) > (M+3) at the moment either half is written. A pair that breaks the rule is not applied, and a sticky error flag is raised instead.

The register map uses a 3-bit address. Address 0 holds the control bits: bit 0 is override, bit 1 is programmed-mode enable and bit 2 is recovery-pair select. Address 1 holds select[4:0]. Address 2 is programmed N and address 3 is programmed M[6:0]. Address 4 is recovery N and address 5 is recovery M[6:0]. Address 6 holds the latched straps and is read-only. Bit 0 of address 7 is the error flag, cleared by writing 1.

Top module: `freq_src_sel`

## Requirements
- R1: While rst_n is low the strap bus is sampled on every clock. After release the latched value never changes, whatever strap_i does, and it reads back at address 6.
- R2: With programmed mode off and recovery inactive, nm_mode_o is 0 and mult_n_o and div_m_o are 0. ratio_idx_o equals the latched straps when override is 0, and select[4:0] when override is 1.
- R3: With programmed mode on and recovery inactive, nm_mode_o is 1 and N/M show the applied programmed pair. The index still follows the override rule of R2.
- R4: A write to an N or M address combines the written value with the stored other half. If (N+3) > (M+3), that pair becomes the applied pair. The field itself always stores the written value.
- R5: If the combined pair breaks the rule, the applied pair is kept and pair_err_o goes to 1 after that write edge. It stays 1 until a write of 1 to bit 0 of address 7; writing 0 there has no effect.
- R6: When recovery is active with recovery-pair select 0, the index is the latched straps and nm_mode_o is 0 with N/M at 0, regardless of override and programmed mode.
- R7: When recovery is active with recovery-pair select 1, nm_mode_o is 1, N/M show the applied recovery pair, and the index follows the override rule.
- R8: The outputs update on the second rising edge after a write or a change of recover_i. freq_chg_o is high for one cycle with that update when the effective index, N, M or mode changed, and stays low when it did not.
- R9: Entry into recovery gives one freq_chg_o pulse even when the effective outputs do not change.
- R10: After reset all fields, applied pairs and the error flag are 0, freq_chg_o is 0, and the outputs show table mode with the latched straps as index.
- R11: Writes to address 6 are ignored, and the strap readback stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_i | input | 5 | Frequency-select strap bus |
| recover_i | input | 1 | Recovery-mode level from the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ratio_idx_o | output | 5 | Active gear/ratio table index |
| mult_n_o | output | 8 | Active N value (0 in table mode) |
| div_m_o | output | 7 | Active M value (0 in table mode) |
| nm_mode_o | output | 1 | 1 = N/M mode, 0 = table mode |
| freq_chg_o | output | 1 | One-cycle pulse on an effective change or recovery entry |
| pair_err_o | output | 1 | Sticky flag for a rejected N/M pair |

## Verification
The assertions check on every cycle that the latched straps stay frozen after reset and that an applied N/M pair moves only on a write to its own halves. They also check that the error flag clears only on a clear write, and that freq_chg_o fires exactly when the effective outputs changed or recovery was entered. Only the bench's scenarios can show the selection itself: the override layering, the two recovery paths, the pair-rule boundary, the field-versus-applied split after a rejected write, and the readback of the strap and error fields. These are shown by comparing every output against a behavioural reference model on each clock.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    parameter int unsigned IDX_W  = 5;
    parameter int unsigned N_W    = 8;
    parameter int unsigned M_W    = 7;
    parameter int unsigned ADDR_W = 3;
    parameter int unsigned DATA_W = 8;

    localparam int unsigned NPAIR     = 2;
    localparam int unsigned PAIR_PROG = 0;
    localparam int unsigned PAIR_RCV  = 1;

    localparam int unsigned CTRL_OVR_BIT  = 0;
    localparam int unsigned CTRL_PEN_BIT  = 1;
    localparam int unsigned CTRL_RSEL_BIT = 2;
    localparam int unsigned STAT_ERR_BIT  = 0;

    // N and M are biased by this constant before the ordering rule is applied
    localparam int unsigned PAIR_BIAS = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_SEL   = 3'd1,
        A_PN    = 3'd2,
        A_PM    = 3'd3,
        A_RN    = 3'd4,
        A_RM    = 3'd5,
        A_STRAP = 3'd6,
        A_STAT  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             ovr;
        logic             pen;
        logic             rsel;
        logic [IDX_W-1:0] sel;
        logic [N_W-1:0]   pn;
        logic [M_W-1:0]   pm;
        logic [N_W-1:0]   rn;
        logic [M_W-1:0]   rm;
    } cfg_t;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } pair_t;

    typedef struct packed {
        logic             nm_mode;
        logic [IDX_W-1:0] idx;
        logic [N_W-1:0]   n;
        logic [M_W-1:0]   m;
    } eff_t;

endpackage

// File: rtl/fsel_regbank.sv
module fsel_regbank
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  strap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              reject_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output cfg_t              cfg_o,
    output logic [IDX_W-1:0]  strap_o,
    output logic              err_o,
    output logic [NPAIR-1:0]  wr_n_o,
    output logic [NPAIR-1:0]  wr_m_o
);

    typedef struct packed {
        cfg_t             cfg;
        logic [IDX_W-1:0] strap;
        logic             err;
    } rb_state_t;

    rb_state_t s_d, s_q;
    logic      clr_req;

    always_comb begin
        s_d     = s_q;
        wr_n_o  = '0;
        wr_m_o  = '0;
        clr_req = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_CTRL: begin
                    s_d.cfg.ovr  = wr_data_i[CTRL_OVR_BIT];
                    s_d.cfg.pen  = wr_data_i[CTRL_PEN_BIT];
                    s_d.cfg.rsel = wr_data_i[CTRL_RSEL_BIT];
                end
                A_SEL: s_d.cfg.sel = wr_data_i[IDX_W-1:0];
                A_PN: begin
                    s_d.cfg.pn        = wr_data_i[N_W-1:0];
                    wr_n_o[PAIR_PROG] = 1'b1;
                end
                A_PM: begin
                    s_d.cfg.pm        = wr_data_i[M_W-1:0];
                    wr_m_o[PAIR_PROG] = 1'b1;
                end
                A_RN: begin
                    s_d.cfg.rn       = wr_data_i[N_W-1:0];
                    wr_n_o[PAIR_RCV] = 1'b1;
                end
                A_RM: begin
                    s_d.cfg.rm       = wr_data_i[M_W-1:0];
                    wr_m_o[PAIR_RCV] = 1'b1;
                end
                A_STAT:  clr_req = wr_data_i[STAT_ERR_BIT];
                default: ; // strap field is read-only
            endcase
        end
        if (reject_i) begin
            s_d.err = 1'b1;
        end else if (clr_req) begin
            s_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.strap <= strap_i;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (reg_addr_e'(rd_addr_i))
            A_CTRL: begin
                rd_data_o[CTRL_OVR_BIT]  = s_q.cfg.ovr;
                rd_data_o[CTRL_PEN_BIT]  = s_q.cfg.pen;
                rd_data_o[CTRL_RSEL_BIT] = s_q.cfg.rsel;
            end
            A_SEL:   rd_data_o[IDX_W-1:0] = s_q.cfg.sel;
            A_PN:    rd_data_o[N_W-1:0]   = s_q.cfg.pn;
            A_PM:    rd_data_o[M_W-1:0]   = s_q.cfg.pm;
            A_RN:    rd_data_o[N_W-1:0]   = s_q.cfg.rn;
            A_RM:    rd_data_o[M_W-1:0]   = s_q.cfg.rm;
            A_STRAP: rd_data_o[IDX_W-1:0] = s_q.strap;
            A_STAT:  rd_data_o[STAT_ERR_BIT] = s_q.err;
            default: ;
        endcase
    end

    assign cfg_o   = s_q.cfg;
    assign strap_o = s_q.strap;
    assign err_o   = s_q.err;

    a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(s_q.strap));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.err) && !$past(clr_req)) |-> s_q.err);

endmodule

// File: rtl/fsel_pair_guard.sv
module fsel_pair_guard
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_i,
    input  logic              wr_m_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [N_W-1:0]    fld_n_i,
    input  logic [M_W-1:0]    fld_m_i,
    output pair_t             appl_o,
    output logic              reject_o
);

    localparam int unsigned TERM_W = N_W + 1;

    pair_t              p_d, p_q;
    pair_t              cand;
    logic [TERM_W-1:0]  n_term;
    logic [TERM_W-1:0]  m_term;
    logic               legal;

    always_comb begin
        cand.n = fld_n_i;
        cand.m = fld_m_i;
        if (wr_n_i) cand.n = wr_data_i[N_W-1:0];
        if (wr_m_i) cand.m = wr_data_i[M_W-1:0];
        n_term   = TERM_W'(cand.n) + TERM_W'(PAIR_BIAS);
        m_term   = TERM_W'(cand.m) + TERM_W'(PAIR_BIAS);
        legal    = n_term > m_term;
        p_d      = p_q;
        reject_o = 1'b0;
        if (wr_n_i || wr_m_i) begin
            if (legal) begin
                p_d = cand;
            end else begin
                reject_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign appl_o = p_q;

    a_r4_pair_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_n_i || wr_m_i) |-> $stable(p_q));

endmodule

// File: rtl/fsel_resolver.sv
module fsel_resolver
    import fsel_pkg::*;
(
    input  cfg_t             cfg_i,
    input  logic [IDX_W-1:0] strap_i,
    input  logic             rcv_i,
    input  pair_t            prog_i,
    input  pair_t            rcvp_i,
    output eff_t             eff_o
);

    logic [IDX_W-1:0] ratio_idx;

    always_comb begin
        ratio_idx = cfg_i.ovr ? cfg_i.sel : strap_i;
        eff_o     = '0;
        if (rcv_i) begin
            if (cfg_i.rsel) begin
                eff_o.nm_mode = 1'b1;
                eff_o.idx     = ratio_idx;
                eff_o.n       = rcvp_i.n;
                eff_o.m       = rcvp_i.m;
            end else begin
                eff_o.idx = strap_i;
            end
        end else if (cfg_i.pen) begin
            eff_o.nm_mode = 1'b1;
            eff_o.idx     = ratio_idx;
            eff_o.n       = prog_i.n;
            eff_o.m       = prog_i.m;
        end else begin
            eff_o.idx = ratio_idx;
        end
    end

endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  strap_i,
    input  logic              recover_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [IDX_W-1:0]  ratio_idx_o,
    output logic [N_W-1:0]    mult_n_o,
    output logic [M_W-1:0]    div_m_o,
    output logic              nm_mode_o,
    output logic              freq_chg_o,
    output logic              pair_err_o
);

    typedef struct packed {
        eff_t eff;
        logic rcv;
        logic rcv_prev;
        logic chg;
    } top_state_t;

    cfg_t             cfg;
    logic [IDX_W-1:0] strap_q;
    logic [NPAIR-1:0] wr_n, wr_m, rej;
    pair_t            appl [NPAIR];
    eff_t             eff_res;
    top_state_t       t_d, t_q;
    logic             rcv_entry;

    fsel_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .reject_i  (|rej),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .cfg_o     (cfg),
        .strap_o   (strap_q),
        .err_o     (pair_err_o),
        .wr_n_o    (wr_n),
        .wr_m_o    (wr_m)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        fsel_pair_guard u_guard (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_n_i    (wr_n[g]),
            .wr_m_i    (wr_m[g]),
            .wr_data_i (wr_data_i),
            .fld_n_i   ((g == PAIR_PROG) ? cfg.pn : cfg.rn),
            .fld_m_i   ((g == PAIR_PROG) ? cfg.pm : cfg.rm),
            .appl_o    (appl[g]),
            .reject_o  (rej[g])
        );
    end

    fsel_resolver u_res (
        .cfg_i   (cfg),
        .strap_i (strap_q),
        .rcv_i   (t_q.rcv),
        .prog_i  (appl[PAIR_PROG]),
        .rcvp_i  (appl[PAIR_RCV]),
        .eff_o   (eff_res)
    );

    assign rcv_entry = t_q.rcv && !t_q.rcv_prev;

    always_comb begin
        t_d          = t_q;
        t_d.rcv      = recover_i;
        t_d.rcv_prev = t_q.rcv;
        t_d.eff      = eff_res;
        t_d.chg      = (eff_res != t_q.eff) || rcv_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q         <= '0;
            t_q.eff.idx <= strap_i;
        end else begin
            t_q <= t_d;
        end
    end

    assign ratio_idx_o = t_q.eff.idx;
    assign mult_n_o    = t_q.eff.n;
    assign div_m_o     = t_q.eff.m;
    assign nm_mode_o   = t_q.eff.nm_mode;
    assign freq_chg_o  = t_q.chg;

    a_r8_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.eff != $past(t_q.eff)) |-> t_q.chg);

    a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.chg |-> ((t_q.eff != $past(t_q.eff)) || $past(rcv_entry)));

    a_r9_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rcv_entry) |-> t_q.chg);

endmodule

// File: tb/freq_src_sel_tb_top.sv
module freq_src_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap_i = 5'h0D;
    logic       recover_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [4:0] ratio_idx_o;
    logic [7:0] mult_n_o;
    logic [6:0] div_m_o;
    logic       nm_mode_o, freq_chg_o, pair_err_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R10";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    freq_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .recover_i(recover_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .ratio_idx_o(ratio_idx_o),
        .mult_n_o(mult_n_o), .div_m_o(div_m_o), .nm_mode_o(nm_mode_o),
        .freq_chg_o(freq_chg_o), .pair_err_o(pair_err_o)
    );

    // behavioural reference model
    int m_ovr, m_pen, m_rsel, m_sel, m_pn, m_pm, m_rn, m_rm;
    int m_apn, m_apm, m_arn, m_arm, m_err, m_strap, m_rcvq, m_rcvp;
    int e_idx, e_n, e_m, e_mode, e_chg;
    int ni, nn, nm, nmode, ratio, d;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_ovr, m_pen, m_rsel, m_sel, m_pn, m_pm, m_rn, m_rm} = '0;
            {m_apn, m_apm, m_arn, m_arm, m_err, m_rcvq, m_rcvp} = '0;
            m_strap = strap_i;
            e_idx = strap_i; e_n = 0; e_m = 0; e_mode = 0; e_chg = 0;
        end else begin
            ratio = m_ovr ? m_sel : m_strap;
            if (m_rcvq != 0 && m_rsel == 0) begin
                ni = m_strap; nn = 0; nm = 0; nmode = 0;
            end else if (m_rcvq != 0) begin
                ni = ratio; nn = m_arn; nm = m_arm; nmode = 1;
            end else if (m_pen != 0) begin
                ni = ratio; nn = m_apn; nm = m_apm; nmode = 1;
            end else begin
                ni = ratio; nn = 0; nm = 0; nmode = 0;
            end
            e_chg = (ni != e_idx || nn != e_n || nm != e_m || nmode != e_mode ||
                     (m_rcvq != 0 && m_rcvp == 0)) ? 1 : 0;
            e_idx = ni; e_n = nn; e_m = nm; e_mode = nmode;
            m_rcvp = m_rcvq;
            m_rcvq = recover_i;
            if (wr_en_i) begin
                d = wr_data_i;
                case (wr_addr_i)
                    3'd0: begin m_ovr = d & 1; m_pen = (d >> 1) & 1; m_rsel = (d >> 2) & 1; end
                    3'd1: m_sel = d & 31;
                    3'd2: begin m_pn = d;
                        if (m_pn + 3 > m_pm + 3) begin m_apn = m_pn; m_apm = m_pm; end else m_err = 1; end
                    3'd3: begin m_pm = d & 127;
                        if (m_pn + 3 > m_pm + 3) begin m_apn = m_pn; m_apm = m_pm; end else m_err = 1; end
                    3'd4: begin m_rn = d;
                        if (m_rn + 3 > m_rm + 3) begin m_arn = m_rn; m_arm = m_rm; end else m_err = 1; end
                    3'd5: begin m_rm = d & 127;
                        if (m_rn + 3 > m_rm + 3) begin m_arn = m_rn; m_arm = m_rm; end else m_err = 1; end
                    3'd7: if ((d & 1) != 0) m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_ovr | (m_pen << 1) | (m_rsel << 2);
            1: return m_sel;
            2: return m_pn;
            3: return m_pm;
            4: return m_rn;
            5: return m_rm;
            6: return m_strap;
            default: return m_err;
        endcase
    endfunction

    // cycle-by-cycle comparison, sampled 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_cmp++;
            if (ratio_idx_o != e_idx || mult_n_o != e_n || div_m_o != e_m ||
                nm_mode_o != e_mode || freq_chg_o != e_chg || pair_err_o != m_err ||
                rd_data_o != model_read(rd_addr_i)) begin
                n_bad++;
                $display("FAIL %s t=%0t: idx=%h n=%h m=%h mode=%b chg=%b err=%b rd=%h expected idx=%h n=%h m=%h mode=%0d chg=%0d err=%0d rd=%h",
                         phase, $time, ratio_idx_o, mult_n_o, div_m_o, nm_mode_o, freq_chg_o,
                         pair_err_o, rd_data_o, e_idx, e_n, e_m, e_mode, e_chg, m_err,
                         model_read(rd_addr_i));
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 8'(v);
        @(negedge clk);
        wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_rcv(input bit v);
        @(negedge clk);
        recover_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        phase = "R10";
        chk("R10 reset index", ratio_idx_o, 5'h0D);
        chk("R10 reset mode", nm_mode_o, 0);
        chk("R10 reset err", pair_err_o, 0);

        phase = "R1";
        strap_i = 5'h12;
        rd_addr_i = 3'd6;
        repeat (3) @(negedge clk);
        chk("R1 strap readback", rd_data_o, 5'h0D);
        chk("R1 index after strap move", ratio_idx_o, 5'h0D);

        phase = "R2";
        wr(1, 8'h07);
        chk("R2 sel ignored with override 0", ratio_idx_o, 5'h0D);
        wr(0, 8'h01);
        chk("R2 override picks sel", ratio_idx_o, 5'h07);

        phase = "R5";
        rd_addr_i = 3'd7;
        wr(3, 10);
        chk("R5 reject (0,10)", pair_err_o, 1);
        wr(7, 0);
        chk("R5 write 0 keeps err", pair_err_o, 1);
        wr(7, 1);
        chk("R5 clear err", pair_err_o, 0);

        phase = "R4";
        wr(2, 40);
        chk("R4 valid pair no err", pair_err_o, 0);
        phase = "R3";
        wr(0, 8'h03);
        chk("R3 mode", nm_mode_o, 1);
        chk("R3 N", mult_n_o, 40);
        chk("R3 M", div_m_o, 10);
        chk("R3 index", ratio_idx_o, 5'h07);

        phase = "R5";
        wr(3, 40);
        chk("R5 equal pair kept M", div_m_o, 10);
        chk("R5 equal pair err", pair_err_o, 1);
        wr(7, 1);
        phase = "R4";
        wr(2, 41);
        chk("R4 boundary N=M+1", mult_n_o, 41);
        chk("R4 boundary M", div_m_o, 40);

        phase = "R11";
        rd_addr_i = 3'd6;
        wr(6, 8'hFF);
        chk("R11 strap write ignored", rd_data_o, 5'h0D);

        phase = "R6";
        set_rcv(1'b1);
        chk("R6 strap index", ratio_idx_o, 5'h0D);
        chk("R6 table mode", nm_mode_o, 0);
        set_rcv(1'b0);

        phase = "R9";
        wr(0, 8'h00);
        set_rcv(1'b1);
        chk("R9 index unchanged", ratio_idx_o, 5'h0D);

        phase = "R7";
        wr(4, 100);
        wr(5, 20);
        wr(0, 8'h05);
        chk("R7 mode", nm_mode_o, 1);
        chk("R7 N", mult_n_o, 100);
        chk("R7 M", div_m_o, 20);
        chk("R7 index", ratio_idx_o, 5'h07);

        phase = "R8";
        wr(1, 8'h07);
        wr(0, 8'h05);
        set_rcv(1'b0);
        chk("R8 back to table index", ratio_idx_o, 5'h07);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule